// File: doc/BRIEF.md
# Multichannel DC Offset Remover with Estimate Hold

This block strips the standing DC level from a stream of signed, already-decimated audio samples. Several channels share one input port in time-multiplexed fashion: each beat carries a sample, the index of the channel it belongs to, and a valid strobe. For every channel the block keeps its own running estimate of the offset. It removes that estimate from each sample of the channel and clamps the result to the sample range.

The estimate is a shift-based leaky integrator. Each channel has a control bit. While the bit is low, the estimate follows the signal. While it is high, the estimate is held at its present value, and that held value is still removed from every sample of the channel. The filter is never bypassed. Because every control bit is low out of reset, all channels begin in tracking mode with a zero estimate.

Top module: `dcr_offset_remover`

## Requirements
- R1: A beat presented with `in_valid` high at a rising clock edge appears on the outputs one cycle later, with `out_valid` high and `out_ch` equal to the input channel index.
- R2: `out_data` is the input sample minus the channel's offset as it stood before this beat. The offset is `floor(A / 2^SHIFT_K)`, where A is the channel's signed accumulator of DATA_W+SHIFT_K+1 bits.
- R3: On a valid beat whose channel has its `hold` bit low, that channel's accumulator becomes A + (sample − offset), with the offset taken from R2.
- R4: On a valid beat whose channel has its `hold` bit (bit index = channel number) high, the accumulator is unchanged, and the held offset is still subtracted from the sample.
- R5: When a channel's `hold` bit returns low, tracking resumes from the held accumulator value, not from zero.
- R6: Each channel's accumulator changes only on valid beats that carry its own index. Traffic on other channels leaves it untouched.
- R7: A cycle with `in_valid` low updates no accumulator and drives `out_valid` low on the next cycle, whatever `in_ch` and `in_data` hold.
- R8: Synchronous active-high `rst` clears every accumulator to zero and drives `out_valid` low. The first sample on a channel after reset therefore passes through unchanged.
- R9: When the difference exceeds the two's complement sample range, `out_data` saturates to 2^(DATA_W−1)−1 or to −2^(DATA_W−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat strobe |
| in_ch | input | $clog2(NUM_CH) | Channel index of the input beat |
| in_data | input | DATA_W | Signed input sample |
| hold | input | NUM_CH | Per-channel estimate hold; bit c controls channel c |
| out_valid | output | 1 | Output beat strobe |
| out_ch | output | $clog2(NUM_CH) | Channel index of the output beat |
| out_data | output | DATA_W | Signed corrected, saturated sample |

## Verification
A corrupted accumulator has no direct port of its own. It shows up at the next valid beat of the affected channel, one cycle later, as a wrong `out_data`. The bench therefore follows every channel with an independent arithmetic model and compares each output beat. An estimate that wrongly moves while held, moves during idle cycles, or moves on another channel's traffic appears as a mismatch on the very next sample of that channel. Repeated identical samples make such drift plain. Saturation faults appear only after a long one-sided run, so the bench builds large offsets before it applies full-scale inputs of the opposite sign.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DEF_DATA_W  = 24;
    localparam int DEF_NUM_CH  = 8;
    localparam int DEF_SHIFT_K = 10;

    // What a channel's accumulator does at the next edge
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_TRACK = 2'd1,
        ACT_HOLD  = 2'd2
    } acc_action_e;

    function automatic acc_action_e pick_action(logic hit, logic held);
        if (!hit)
            return ACT_IDLE;
        else if (held)
            return ACT_HOLD;
        else
            return ACT_TRACK;
    endfunction

endpackage

// File: rtl/dcr_sat_sub.sv
module dcr_sat_sub #(
    parameter int DATA_W = dcr_pkg::DEF_DATA_W
) (
    input  logic signed [DATA_W-1:0] minuend,
    input  logic signed [DATA_W-1:0] subtrahend,
    output logic signed [DATA_W-1:0] result
);
    localparam int WIDE_W = DATA_W + 1;
    localparam logic signed [WIDE_W-1:0] POS_LIM = {2'b00, {(DATA_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] NEG_LIM = {2'b11, {(DATA_W-1){1'b0}}};

    logic signed [WIDE_W-1:0] diff_wide;

    always_comb begin
        diff_wide = {minuend[DATA_W-1], minuend} - {subtrahend[DATA_W-1], subtrahend};
        if (diff_wide > POS_LIM)
            result = POS_LIM[DATA_W-1:0];
        else if (diff_wide < NEG_LIM)
            result = NEG_LIM[DATA_W-1:0];
        else
            result = diff_wide[DATA_W-1:0];
    end

    // R9
    always_comb begin
        if (!minuend[DATA_W-1] && (subtrahend[DATA_W-1] || subtrahend == '0))
            sign_keep_chk: assert (!result[DATA_W-1]);
    end

endmodule

// File: rtl/dcr_est_bank.sv
module dcr_est_bank
    import dcr_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int NUM_CH  = DEF_NUM_CH,
    parameter int SHIFT_K = DEF_SHIFT_K
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_en,
    input  logic [$clog2(NUM_CH)-1:0]  upd_ch,
    input  logic signed [DATA_W-1:0]   upd_sample,
    input  logic [NUM_CH-1:0]          hold,
    output logic signed [DATA_W-1:0]   offset_rd
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int ACC_W = DATA_W + SHIFT_K + 1;

    logic signed [ACC_W-1:0] acc_q [NUM_CH];
    logic signed [ACC_W-1:0] acc_sel;
    logic signed [ACC_W-1:0] off_wide;
    logic signed [ACC_W-1:0] step;

    // Offset of the addressed channel, before this beat's update
    always_comb begin
        acc_sel   = acc_q[upd_ch];
        off_wide  = acc_sel >>> SHIFT_K;
        offset_rd = off_wide[DATA_W-1:0];
        step      = ACC_W'(upd_sample) - off_wide;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        acc_action_e act;

        always_comb begin
            act = pick_action(upd_en && (upd_ch == CH_W'(c)), hold[c]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[c] <= '0;
            end else begin
                case (act)
                    ACT_TRACK: acc_q[c] <= acc_q[c] + step;
                    default:   acc_q[c] <= acc_q[c];
                endcase
            end
        end

        // R4
        held_stable_chk: assert property (@(posedge clk) disable iff (rst)
            hold[c] |=> $stable(acc_q[c]));

        // R7
        idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !upd_en |=> $stable(acc_q[c]));

        // R6
        other_ch_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (upd_ch != CH_W'(c)) |=> $stable(acc_q[c]));

        // R8
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> (acc_q[c] == '0));
    end

endmodule

// File: rtl/dcr_offset_remover.sv
module dcr_offset_remover
    import dcr_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int NUM_CH  = DEF_NUM_CH,
    parameter int SHIFT_K = DEF_SHIFT_K
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [$clog2(NUM_CH)-1:0]         in_ch,
    input  logic signed [DATA_W-1:0]          in_data,
    input  logic [NUM_CH-1:0]                 hold,
    output logic                              out_valid,
    output logic [$clog2(NUM_CH)-1:0]         out_ch,
    output logic signed [DATA_W-1:0]          out_data
);
    localparam int CH_W = $clog2(NUM_CH);

    logic signed [DATA_W-1:0] cur_offset;
    logic signed [DATA_W-1:0] corrected;

    dcr_est_bank #(
        .DATA_W  (DATA_W),
        .NUM_CH  (NUM_CH),
        .SHIFT_K (SHIFT_K)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (in_valid),
        .upd_ch     (in_ch),
        .upd_sample (in_data),
        .hold       (hold),
        .offset_rd  (cur_offset)
    );

    dcr_sat_sub #(
        .DATA_W (DATA_W)
    ) u_sub (
        .minuend    (in_data),
        .subtrahend (cur_offset),
        .result     (corrected)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_ch   <= in_ch;
                out_data <= corrected;
            end
        end
    end

    // R1
    beat_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |-> (out_valid && out_ch == $past(in_ch)));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/sim_dcr_offset_remover.sv
module sim_dcr_offset_remover;
    localparam int DATA_W  = 24;
    localparam int NUM_CH  = 8;
    localparam int SHIFT_K = 10;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam longint MAXV = (64'sd1 <<< (DATA_W-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DATA_W-1));

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [CH_W-1:0] in_ch;
    logic signed [DATA_W-1:0] in_data;
    logic [NUM_CH-1:0] hold;
    logic out_valid;
    logic [CH_W-1:0] out_ch;
    logic signed [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    longint m_acc [NUM_CH];

    always #2 clk = ~clk;

    dcr_offset_remover #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .SHIFT_K(SHIFT_K)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
        .hold(hold), .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clamp(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic send(input int ch, input longint val, input string req);
        longint off;
        longint exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_ch    = CH_W'(ch);
        in_data  = DATA_W'(val);
        @(posedge clk);
        #1;
        off = m_acc[ch] >>> SHIFT_K;
        exp = clamp(val - off);
        if (!hold[ch]) m_acc[ch] = m_acc[ch] + (val - off);
        checks++;
        if (!out_valid || out_ch != CH_W'(ch) || longint'(out_data) != exp) begin
            errors++;
            $display("FAIL %s actual v=%0b ch=%0d data=%0d expected v=1 ch=%0d data=%0d",
                     req, out_valid, out_ch, out_data, ch, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NUM_CH; c++) m_acc[c] = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R8 out_valid after reset", out_valid, 0);
        send(3, 12345, "R8 first sample passes unchanged");
        send(4, -777, "R8 first sample passes unchanged");
        go_idle();
    endtask

    task automatic t_converge();
        for (int i = 0; i < 40; i++) send(2, 50000, "R2 R3 constant input tracking");
        for (int i = 0; i < 20; i++) send(2, 50000 + ((i % 2) ? 3000 : -3000), "R2 R3 alternating input");
        go_idle();
    endtask

    task automatic t_independent();
        send(5, 999, "R6 untouched channel passes unchanged");
        for (int i = 0; i < 10; i++) send(1, -20000 + i * 100, "R6 interleave ch1");
        send(2, 50000, "R6 ch2 unaffected by ch1 traffic");
        send(5, 999, "R6 ch5 tracks only its own beats");
        go_idle();
    endtask

    task automatic t_hold();
        @(negedge clk);
        hold = 8'b0000_0100;
        for (int i = 0; i < 8; i++) send(2, 60000 + i * 7, "R4 held offset still subtracted");
        send(2, 0, "R4 held offset subtracted from zero input");
        send(2, 0, "R4 held estimate unchanged");
        send(3, 100, "R4 other channel still tracks while ch2 held");
        @(negedge clk);
        hold = '0;
        for (int i = 0; i < 6; i++) send(2, 60000, "R5 tracking resumes from held value");
        go_idle();
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_ch = 3'd2;
        in_data = 24'sh7FFFFF;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #1;
            check("R7 out_valid low after idle cycle", out_valid, 0);
        end
        send(2, 60000, "R7 idle cycles did not update estimate");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 1200; i++) send(6, MINV, "R2 build negative offset");
        send(6, MAXV, "R9 positive saturation");
        for (int i = 0; i < 1200; i++) send(7, MAXV, "R2 build positive offset");
        send(7, MINV, "R9 negative saturation");
        go_idle();
    endtask

    task automatic t_reset_mid();
        do_reset();
        check("R8 out_valid low after mid-run reset", out_valid, 0);
        send(6, MAXV, "R8 accumulator cleared by reset");
        send(2, 60000, "R8 accumulator cleared by reset");
        go_idle();
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_ch = '0;
        in_data = '0;
        hold = '0;
        t_reset_state();
        t_converge();
        t_independent();
        t_hold();
        t_idle();
        t_saturate();
        t_reset_mid();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule